// File: doc/BRIEF.md
# Legacy Interrupt Replacement Router

This block sits beside an event timer block and decides who owns two legacy interrupt lines: output line 0 (normally fed by an interval timer) and output line 8 (normally fed by a real-time clock). A single bit in the timer block's general configuration register selects the owner. With the bit clear, the two legacy interrupt levels are forwarded to their lines. With the bit set, the legacy sources are shut out, the interval timer is told to stop through a dedicated enable output, and the lines carry the interrupt outputs of two chosen event timer channels.

Mode changes are detected only on a configuration write, by comparing the stored value with the written one. Entering replacement mode lowers both lines and drops the interval timer enable. Leaving it lowers line 0 (which stays low until the interval timer input next changes), raises the enable, and puts back on line 8 the real-time clock level, which the block keeps sampling the whole time. Each legacy line is an event-driven copy: it takes a new value when its source input changes, not on every cycle.

Top module: `legacy_route`

## Requirements
- R1: After reset `tmr_en_o` is 1, `cfg_o` is 0 (normal mode), and `line0_o` and `line8_o` are 0.
- R2: In normal mode, when legacy input index 0 (interval timer) differs from its value one cycle earlier, `line0_o` takes the new level after the next rising clock edge.
- R3: In normal mode, when legacy input index 1 (real-time clock) differs from its value one cycle earlier, `line8_o` takes the new level after the next rising clock edge.
- R4: A write whose bit 1 (the replacement bit) is 1 while the stored bit is 0 drives `tmr_en_o` low after that edge and clears the held levels of both lines.
- R5: In replacement mode `line0_o` equals channel interrupt 0 and `line8_o` equals channel interrupt 1 at all times; legacy input changes have no effect on either line.
- R6: A write whose bit 1 is 0 while the stored bit is 1 raises `tmr_en_o` and returns both lines to normal mode, with `line0_o` low until the interval timer input next changes.
- R7: On leaving replacement mode `line8_o` is driven to the real-time clock level sampled in the cycle before the write, including any change made while the mode was active.
- R8: A write that leaves bit 1 unchanged alters neither `tmr_en_o` nor the held line levels.
- R9: `cfg_o` holds the last written word; bits other than bit 1 have no effect on routing.
- R10: In normal mode the channel interrupts have no effect on `line0_o` or `line8_o`.
- R11: When a write leaving replacement mode coincides with a change of the interval timer input, the write wins and `line0_o` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the general configuration register |
| cfg_wdata_i | input | CFG_W | Write data; bit REPL_BIT selects replacement mode |
| cfg_o | output | CFG_W | Stored general configuration |
| legacy_irq_i | input | 2 | Legacy levels: index 0 interval timer, index 1 real-time clock |
| chan_irq_i | input | NUM_CHAN | Event timer channel interrupt levels |
| line0_o | output | 1 | Output interrupt line 0 |
| line8_o | output | 1 | Output interrupt line 8 (real-time clock line) |
| tmr_en_o | output | 1 | Enable for the interval timer |

## Verification
The bench builds the block with its defaults: a 32-bit configuration word, the replacement bit at position 1 and three channels with channels 0 and 1 routed to the lines. Directed steps cover each mode transition, the replay of a real-time clock level changed while blocked, and the write that collides with an interval timer change; a long pseudo-random sweep then drives every combination of write strobe, mode bit, both legacy levels and all eight channel patterns against an arithmetic model built from the requirements, which reaches every ordering of transitions and input changes.

// File: rtl/legacy_route_pkg.sv
package legacy_route_pkg;

  typedef enum logic [0:0] {
    SRC_TMR = 1'b0,
    SRC_RTC = 1'b1
  } legacy_src_e;

  localparam int unsigned NUM_SRC = 2;

  typedef struct packed {
    logic enter;
    logic leave;
  } mode_evt_t;

endpackage

// File: rtl/legacy_route_cfg.sv
module legacy_route_cfg
  import legacy_route_pkg::*;
#(
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned REPL_BIT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             repl_o,
  output mode_evt_t        evt_o,
  output logic             tmr_en_o
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] diff;
  logic             tmr_en_q;

  // Edges come from old-vs-new comparison on the write, not from sampling.
  assign diff      = cfg_q ^ wdata_i;
  assign evt_o.enter = we_i & diff[REPL_BIT] &  wdata_i[REPL_BIT];
  assign evt_o.leave = we_i & diff[REPL_BIT] & ~wdata_i[REPL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_en_q <= 1'b1;
    end else if (evt_o.enter) begin
      tmr_en_q <= 1'b0;
    end else if (evt_o.leave) begin
      tmr_en_q <= 1'b1;
    end
  end

  assign cfg_o    = cfg_q;
  assign repl_o   = cfg_q[REPL_BIT];
  assign tmr_en_o = tmr_en_q;

  AST_ENTER_STOPS_TMR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.enter |=> !tmr_en_o); // R4
  AST_LEAVE_STARTS_TMR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.leave |=> tmr_en_o); // R6
  AST_EN_STABLE_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_o.enter || evt_o.leave) |=> $stable(tmr_en_o)); // R8
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_o.enter, evt_o.leave})); // R4

endmodule

// File: rtl/legacy_route_track.sv
module legacy_route_track
  import legacy_route_pkg::*;
#(
  parameter bit REPLAY = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      src_i,
  input  logic      repl_i,
  input  mode_evt_t evt_i,
  output logic      line_o
);

  logic lvl_q;
  logic line_q;
  logic src_chg;
  logic exit_val;

  assign src_chg = src_i ^ lvl_q;

  // Source level is latched every cycle, whatever the mode.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= src_i;
  end

  generate
    if (REPLAY) begin : g_replay
      assign exit_val = lvl_q;
    end else begin : g_clear
      assign exit_val = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
    end else if (evt_i.enter) begin
      line_q <= 1'b0;
    end else if (evt_i.leave) begin
      line_q <= exit_val;
    end else if (!repl_i && src_chg) begin
      line_q <= src_i;
    end
  end

  assign line_o = line_q;

  AST_ENTER_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.enter |=> !line_o); // R4
  AST_LEAVE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.leave |=> line_o == (REPLAY ? $past(lvl_q) : 1'b0)); // R7
  AST_FROZEN_IN_REPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repl_i && !evt_i.leave) |=> $stable(line_o)); // R5
  AST_FOLLOW_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!repl_i && !evt_i.enter && !evt_i.leave && src_chg) |=> line_o == $past(src_i)); // R2

endmodule

// File: rtl/legacy_route_mux.sv
module legacy_route_mux #(
  parameter int unsigned NUM_CHAN = 3,
  parameter int unsigned CH_SEL   = 0
) (
  input  logic                repl_i,
  input  logic                held_i,
  input  logic [NUM_CHAN-1:0] chan_irq_i,
  output logic                line_o
);

  logic chan_lvl;

  generate
    if (CH_SEL < NUM_CHAN) begin : g_chan
      assign chan_lvl = chan_irq_i[CH_SEL];
    end else begin : g_none
      assign chan_lvl = 1'b0;
    end
  endgenerate

  // Held level is zero while replacing, so the OR leaves only the channel.
  assign line_o = (repl_i & chan_lvl) | (~repl_i & held_i);

endmodule

// File: rtl/legacy_route.sv
module legacy_route
  import legacy_route_pkg::*;
#(
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned REPL_BIT = 1,
  parameter int unsigned NUM_CHAN = 3,
  parameter int unsigned CH_LINE0 = 0,
  parameter int unsigned CH_LINE8 = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  output logic [CFG_W-1:0]    cfg_o,
  input  logic [NUM_SRC-1:0]  legacy_irq_i,
  input  logic [NUM_CHAN-1:0] chan_irq_i,
  output logic                line0_o,
  output logic                line8_o,
  output logic                tmr_en_o
);

  localparam int unsigned NUM_LINES = NUM_SRC;

  logic                 repl;
  mode_evt_t            evt;
  logic [NUM_LINES-1:0] held;
  logic [NUM_LINES-1:0] line;

  legacy_route_cfg #(
    .CFG_W    (CFG_W),
    .REPL_BIT (REPL_BIT)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .cfg_o    (cfg_o),
    .repl_o   (repl),
    .evt_o    (evt),
    .tmr_en_o (tmr_en_o)
  );

  for (genvar s = 0; s < NUM_LINES; s++) begin : g_line
    localparam bit          IS_RTC = (s == int'(SRC_RTC));
    localparam int unsigned CH     = IS_RTC ? CH_LINE8 : CH_LINE0;

    legacy_route_track #(
      .REPLAY (IS_RTC)
    ) u_track (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (legacy_irq_i[s]),
      .repl_i (repl),
      .evt_i  (evt),
      .line_o (held[s])
    );

    legacy_route_mux #(
      .NUM_CHAN (NUM_CHAN),
      .CH_SEL   (CH)
    ) u_mux (
      .repl_i     (repl),
      .held_i     (held[s]),
      .chan_irq_i (chan_irq_i),
      .line_o     (line[s])
    );
  end

  assign line0_o = line[SRC_TMR];
  assign line8_o = line[SRC_RTC];

  AST_EN_LOW_IN_REPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl |-> !tmr_en_o); // R5
  AST_NO_CHAN_IN_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!repl && $changed(chan_irq_i) && !evt.enter && !evt.leave
      && $stable(legacy_irq_i)) |=> $stable(line0_o)); // R10

endmodule

// File: tb/legacy_route_test.sv
module legacy_route_test;

  localparam int unsigned CFG_W = 32;
  localparam int unsigned NCH   = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [CFG_W-1:0] cfg_wdata_i = '0;
  logic [CFG_W-1:0] cfg_o;
  logic [1:0]       legacy_irq_i = '0;
  logic [NCH-1:0]   chan_irq_i = '0;
  logic             line0_o, line8_o, tmr_en_o;

  int unsigned vectors = 0;
  int unsigned errors  = 0;
  bit          done    = 1'b0;

  // reference state
  bit             m_repl, m_en, m_l0, m_l8, m_tmr, m_rtc;
  logic [CFG_W-1:0] m_cfg;

  always #5 clk = ~clk;

  legacy_route uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_o        (cfg_o),
    .legacy_irq_i (legacy_irq_i),
    .chan_irq_i   (chan_irq_i),
    .line0_o      (line0_o),
    .line8_o      (line8_o),
    .tmr_en_o     (tmr_en_o)
  );

  task automatic check(input string tag, input string what, input logic [CFG_W-1:0] act,
                       input logic [CFG_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    bit e0, e8;
    e0 = m_repl ? chan_irq_i[0] : m_l0;
    e8 = m_repl ? chan_irq_i[1] : m_l8;
    check(tag, "line0", CFG_W'(line0_o), CFG_W'(e0));
    check(tag, "line8", CFG_W'(line8_o), CFG_W'(e8));
    check(tag, "tmr_en", CFG_W'(tmr_en_o), CFG_W'(m_en));
    check(tag, "cfg", cfg_o, m_cfg);
  endtask

  // Apply one cycle of stimulus, advance the model, check after the edge.
  task automatic step(input bit we, input logic [CFG_W-1:0] wd, input bit tmr,
                      input bit rtc, input logic [NCH-1:0] ch, input string tag);
    bit enter, leave;
    @(negedge clk);
    cfg_we_i = we; cfg_wdata_i = wd;
    legacy_irq_i = {rtc, tmr}; chan_irq_i = ch;
    enter = we && wd[1] && !m_repl;
    leave = we && !wd[1] && m_repl;
    if (enter)                      m_l0 = 1'b0;
    else if (leave)                 m_l0 = 1'b0;
    else if (!m_repl && tmr != m_tmr) m_l0 = tmr;
    if (enter)                      m_l8 = 1'b0;
    else if (leave)                 m_l8 = m_rtc;
    else if (!m_repl && rtc != m_rtc) m_l8 = rtc;
    if (enter) m_en = 1'b0;
    if (leave) m_en = 1'b1;
    if (we) begin m_cfg = wd; m_repl = wd[1]; end
    m_tmr = tmr; m_rtc = rtc;
    @(posedge clk); #2;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_repl = 0; m_en = 1; m_l0 = 0; m_l8 = 0; m_tmr = 0; m_rtc = 0; m_cfg = '0;
    repeat (3) @(posedge clk);
    #2; compare("R1");
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #2; compare("R1");

    // R2, R3, R10: normal-mode forwarding, channels ignored
    step(0, '0, 1, 0, 3'b011, "R2");
    step(0, '0, 1, 1, 3'b000, "R3");
    step(0, '0, 0, 1, 3'b111, "R10");
    step(0, '0, 0, 0, 3'b101, "R3");
    // R9: other bits only change cfg_o
    step(1, 32'hFFFF_FFFD, 1, 1, 3'b000, "R9");
    step(1, 32'h0000_0001, 1, 1, 3'b000, "R8");
    // R4: enter
    step(1, 32'h0000_0002, 1, 1, 3'b000, "R4");
    // R5: legacy changes ignored, channels pass
    step(0, '0, 0, 0, 3'b001, "R5");
    step(0, '0, 1, 0, 3'b010, "R5");
    step(1, 32'h8000_0006, 0, 1, 3'b011, "R8");
    // R6/R7: leave, rtc changed while blocked is replayed, line0 low
    step(1, 32'h0000_0000, 0, 1, 3'b011, "R7");
    step(0, '0, 0, 1, 3'b000, "R6");
    step(0, '0, 1, 1, 3'b000, "R2");
    // R11: leave collides with timer change
    step(1, 32'h0000_0002, 1, 0, 3'b000, "R4");
    step(1, 32'h0000_0000, 0, 0, 3'b000, "R11");
    step(0, '0, 0, 0, 3'b000, "R11");

    // sweep: all input patterns in both modes
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5], {lfsr[15:0], 16'(i)} & 32'hFFFF_FFF7 | CFG_W'(lfsr[1] << 1),
           lfsr[2], lfsr[3], {lfsr[9], lfsr[8], lfsr[4]}, "R5");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule